// File: doc/BRIEF.md
# Receive Idle Timeout Interrupt

This block sits beside the receive FIFO of a serial port and signals software when characters are stuck in the FIFO because the line has gone quiet. It counts baud-rate ticks after the most recent character enters the FIFO. When the count reaches a programmable threshold while the FIFO still holds data, it raises a level interrupt. Software can then drain a partly filled FIFO without waiting for a full-level trigger.

The threshold and an enable bit live in one 8-bit control register that is written and read through a plain strobe-and-data port. The interrupt is also gated by the receive-data interrupt enable, which comes from the port's interrupt enable register. The interrupt drops as soon as another character arrives or the FIFO runs empty. All logic runs on one clock with a synchronous active-high reset. The baud tick is a one-cycle enable strobe.

Top module: `rx_idle_timeout`

## Requirements
- R1: After reset the control register reads 0x00 and `irq_timeout` is 0.
- R2: A `fifo_push` pulse clears the idle counter to zero, and counting restarts from zero afterwards.
- R3: The idle counter advances by one only in cycles where `baud_tick` is 1. System clock cycles without a tick leave it unchanged.
- R4: When the idle counter equals the threshold (control bits 6:0), `irq_timeout` is 1 in the following clock cycle.
- R5: `irq_timeout` can be 1 only when the enable (control bit 7) and `rx_data_ie` are both 1.
- R6: A `fifo_push` pulse or `fifo_empty` = 1 forces `irq_timeout` to 0 in the next cycle.
- R7: Once the counter equals the threshold it stops advancing, so the interrupt stays asserted until a clearing event.
- R8: While `fifo_empty` is 1 the idle counter is held at zero.
- R9: A threshold of zero never produces an interrupt.
- R10: `ctrl_rdata` returns the enable bit at bit 7 and the threshold at bits 6:0 exactly as last written with `ctrl_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle strobe at the baud rate |
| fifo_push | input | 1 | Pulse: RX FIFO accepted a new character |
| fifo_empty | input | 1 | RX FIFO holds no data |
| rx_data_ie | input | 1 | Receive-data interrupt enable |
| ctrl_wr | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 8 | Write data: bit 7 enable, bits 6:0 threshold |
| ctrl_rdata | output | 8 | Current control register contents |
| irq_timeout | output | 1 | Level timeout interrupt |

## Verification
The hardest case to reach is proving that the counter stays frozen while the FIFO is empty, because a frozen counter and an empty FIFO both keep the interrupt low. The bench applies ticks while the FIFO is empty, then clears the empty flag without a push. It shows that exactly the threshold number of further ticks is needed before the interrupt appears, one fewer is not enough, and this count could only hold if the counter had stayed at zero. The hold-at-match behaviour is reached by sending far more ticks than the threshold and checking that the interrupt is still present, and the 127 boundary by running the full count.

// File: rtl/rx_idle_timeout_pkg.sv
package rx_idle_timeout_pkg;
  localparam int RIT_THR_W = 7;

  function automatic logic thr_hit(input logic [31:0] cnt, input logic [31:0] thr);
    return (thr != 0) && (cnt == thr);
  endfunction
endpackage

// File: rtl/rit_ctrl_reg.sv
module rit_ctrl_reg #(
  parameter int THR_W = 7,
  localparam int REG_W = THR_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic             enable,
  output logic [THR_W-1:0] thresh,
  output logic [REG_W-1:0] rdata
);
  logic [REG_W-1:0] reg_q;

  always_ff @(posedge clk) begin
    if (rst)     reg_q <= '0;
    else if (wr) reg_q <= wdata;
  end

  assign enable = reg_q[REG_W-1];
  assign thresh = reg_q[THR_W-1:0];
  assign rdata  = reg_q;

  a_r10_readback: assert property (@(posedge clk) disable iff (rst)
    wr |=> (rdata == $past(wdata)));
endmodule

// File: rtl/rit_idle_counter.sv
module rit_idle_counter #(
  parameter int THR_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             restart,
  input  logic             empty,
  input  logic [THR_W-1:0] thresh,
  output logic [THR_W-1:0] count
);
  localparam logic [THR_W-1:0] CNT_MAX = {THR_W{1'b1}};

  logic [THR_W-1:0] cnt_q;
  logic             frozen;

  assign frozen = (cnt_q == thresh) || (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst)                    cnt_q <= '0;
    else if (restart || empty)  cnt_q <= '0;
    else if (tick && !frozen)   cnt_q <= cnt_q + 1'b1;
  end

  assign count = cnt_q;

  a_r2_push_clears: assert property (@(posedge clk) disable iff (rst)
    restart |=> (count == '0));
  a_r8_empty_holds_zero: assert property (@(posedge clk) disable iff (rst)
    empty |=> (count == '0));
  a_r3_no_tick_no_step: assert property (@(posedge clk) disable iff (rst)
    (!tick && !restart && !empty) |=> $stable(count));
  a_r7_hold_at_match: assert property (@(posedge clk) disable iff (rst)
    ((count == thresh) && !restart && !empty) |=> (count == $past(count)));
endmodule

// File: rtl/rit_irq_gen.sv
module rit_irq_gen #(
  parameter int THR_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [THR_W-1:0] count,
  input  logic [THR_W-1:0] thresh,
  input  logic             enable,
  input  logic             rx_ie,
  input  logic             push,
  input  logic             empty,
  output logic             irq
);
  import rx_idle_timeout_pkg::*;

  logic irq_q;
  logic hit;

  assign hit = thr_hit(32'(count), 32'(thresh));

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= hit && enable && rx_ie && !push && !empty;
  end

  assign irq = irq_q;

  a_r5_gated: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(enable && rx_ie));
  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    (push || empty) |=> !irq);
  a_r9_zero_thresh: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(thresh) != '0));
endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout #(
  parameter int THR_W = rx_idle_timeout_pkg::RIT_THR_W,
  localparam int REG_W = THR_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             baud_tick,
  input  logic             fifo_push,
  input  logic             fifo_empty,
  input  logic             rx_data_ie,
  input  logic             ctrl_wr,
  input  logic [REG_W-1:0] ctrl_wdata,
  output logic [REG_W-1:0] ctrl_rdata,
  output logic             irq_timeout
);
  logic             en;
  logic [THR_W-1:0] thr;
  logic [THR_W-1:0] cnt;

  rit_ctrl_reg #(.THR_W(THR_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr(ctrl_wr), .wdata(ctrl_wdata),
    .enable(en), .thresh(thr), .rdata(ctrl_rdata)
  );

  rit_idle_counter #(.THR_W(THR_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(baud_tick), .restart(fifo_push),
    .empty(fifo_empty), .thresh(thr), .count(cnt)
  );

  rit_irq_gen #(.THR_W(THR_W)) u_irq (
    .clk(clk), .rst(rst), .count(cnt), .thresh(thr), .enable(en),
    .rx_ie(rx_data_ie), .push(fifo_push), .empty(fifo_empty), .irq(irq_timeout)
  );

  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!irq_timeout && ctrl_rdata == '0));
endmodule

// File: tb/rx_idle_timeout_tb.sv
`timescale 1ns/1ps
module rx_idle_timeout_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0, fifo_push = 1'b0, fifo_empty = 1'b1, rx_data_ie = 1'b0;
  logic       ctrl_wr = 1'b0;
  logic [7:0] ctrl_wdata = '0;
  logic [7:0] ctrl_rdata;
  logic       irq_timeout;
  int         n_run = 0, n_fail = 0;
  bit         done = 0;

  rx_idle_timeout u_dut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .fifo_push(fifo_push),
    .fifo_empty(fifo_empty), .rx_data_ie(rx_data_ie), .ctrl_wr(ctrl_wr),
    .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata), .irq_timeout(irq_timeout)
  );

  always #2.5 clk = ~clk;

  // vector: {thr[6:0], en, ie, ticks[7:0], expected irq}
  localparam int NV = 10;
  localparam logic [17:0] VEC [NV] = '{
    {7'd5,   1'b1, 1'b1, 8'd5,   1'b1},  // R4
    {7'd5,   1'b1, 1'b1, 8'd4,   1'b0},  // R4 one short
    {7'd5,   1'b0, 1'b1, 8'd5,   1'b0},  // R5 enable off
    {7'd5,   1'b1, 1'b0, 8'd5,   1'b0},  // R5 ie off
    {7'd0,   1'b1, 1'b1, 8'd3,   1'b0},  // R9
    {7'd0,   1'b1, 1'b1, 8'd200, 1'b0},  // R9 long run
    {7'd127, 1'b1, 1'b1, 8'd126, 1'b0},  // R4 max minus one
    {7'd127, 1'b1, 1'b1, 8'd127, 1'b1},  // R4 max
    {7'd1,   1'b1, 1'b1, 8'd1,   1'b1},  // R4 min
    {7'd3,   1'b1, 1'b1, 8'd10,  1'b1}   // R7 hold past match
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] d);
    ctrl_wr = 1'b1; ctrl_wdata = d;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic push1();
    fifo_push = 1'b1; @(negedge clk); fifo_push = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      baud_tick = 1'b1; @(negedge clk);
      baud_tick = 1'b0; @(negedge clk);
    end
  endtask

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rdata", ctrl_rdata, 8'h00);
    chk("R1 irq", {7'd0, irq_timeout}, 8'd0);

    wr_ctrl(8'hA5);
    chk("R10 readback", ctrl_rdata, 8'hA5);
    wr_ctrl(8'h3C);
    chk("R10 readback2", ctrl_rdata, 8'h3C);

    for (int v = 0; v < NV; v++) begin
      wr_ctrl({VEC[v][10], VEC[v][17:11]});
      rx_data_ie = VEC[v][9];
      fifo_empty = 1'b0;
      push1();
      ticks(int'(VEC[v][8:1]));
      @(negedge clk);
      chk($sformatf("R4/R5/R7/R9 vec%0d", v), {7'd0, irq_timeout}, {7'd0, VEC[v][0]});
      fifo_empty = 1'b1; @(negedge clk);
    end

    // R6: push clears an asserted interrupt, then R2 restart
    wr_ctrl(8'h84); rx_data_ie = 1'b1; fifo_empty = 1'b0;
    push1(); ticks(4); @(negedge clk);
    chk("R6 pre", {7'd0, irq_timeout}, 8'd1);
    push1();
    chk("R6 push clears", {7'd0, irq_timeout}, 8'd0);
    ticks(3); @(negedge clk);
    chk("R2 restart short", {7'd0, irq_timeout}, 8'd0);
    ticks(1); @(negedge clk);
    chk("R2 restart full", {7'd0, irq_timeout}, 8'd1);

    // R6: empty clears
    fifo_empty = 1'b1; @(negedge clk);
    chk("R6 empty clears", {7'd0, irq_timeout}, 8'd0);

    // R8: counter frozen at zero while empty, then no push
    ticks(10);
    fifo_empty = 1'b0; @(negedge clk);
    ticks(3); @(negedge clk);
    chk("R8 held at zero", {7'd0, irq_timeout}, 8'd0);
    ticks(1); @(negedge clk);
    chk("R8 count from zero", {7'd0, irq_timeout}, 8'd1);

    // R3: clock cycles without tick do not count
    push1();
    repeat (40) @(negedge clk);
    chk("R3 no tick", {7'd0, irq_timeout}, 8'd0);

    // R5: dropping rx_data_ie removes interrupt
    ticks(4); @(negedge clk);
    chk("R5 pre", {7'd0, irq_timeout}, 8'd1);
    rx_data_ie = 1'b0; @(negedge clk);
    chk("R5 ie dropped", {7'd0, irq_timeout}, 8'd0);

    // R1: reset mid-operation
    rx_data_ie = 1'b1; @(negedge clk);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R1 reset rdata", ctrl_rdata, 8'h00);
    chk("R1 reset irq", {7'd0, irq_timeout}, 8'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule